// File: doc/BRIEF.md
# Addressed Peripheral Select Responder

This block sits on the peripheral side of an 8-bit bus that a single host fully controls. The host moves every byte with a set of active-low strobes: one for address out, one for command out, one for data out, two gates that read status or data back, and one bus-wide reset. The data lines idle high through pull-ups. The host places a logical 1 on a line by pulling it low, and the device answers the same way, through open-drain drivers.

Selection happens in two steps. An address-out strobe drops any current selection on every device on the bus. The device whose configured address equals the byte on the bus becomes preselected. The first status gate after that returns the device's identity (answer-back) byte instead of status, and it completes the selection. Once fully selected, the device takes command and data bytes from the host. It returns the last command as its status and the last data byte as its data, which forms a simple loopback. Valid device addresses run from 1 to 255. Address 0 belongs to the keyboard/display device and must never be configured.

All strobes are sampled on the local clock. A strobe acts on the first clock edge at which it is seen asserted after being seen deasserted.

Top module: `periph_select_resp`

## Requirements
- R1: After `rst_n` the device is deselected. Both drivers are off, with `drive_en_o`=0 and `pull_low_o`=0, and the command and data registers hold 0.
- R2: An address-out strobe whose logical bus byte equals `DEV_ADDR` preselects the device. The next status gate drives the answer-back byte and leaves the device fully selected.
- R3: An address-out strobe with any other byte deselects the device. After that, gates produce no drive.
- R4: While fully selected, a status gate drives the last command byte.
- R5: While fully selected, a command-out strobe latches the logical bus byte as the command, and a data-out strobe latches it as data. A data gate drives the last data byte.
- R6: Command and data strobes leave both registers unchanged unless the device is fully selected. A data gate in the preselected state produces no drive and does not complete the selection.
- R7: The drivers are enabled only while a gate strobe that this device accepted is still asserted. They are released in the same cycle the strobe deasserts, before the next clock edge.
- R8: The bus is active low. The logical byte is the inverse of the pin levels (`bus_in_n`), and `pull_low_o` bit i is 1 exactly when the driven byte has bit i set.
- R9: While the bus reset strobe is asserted, the device returns to deselected, turns off its drivers and clears its command and data registers.
- R10: A fully selected device addressed away by another address is deselected. When it is later reselected, the first status gate again returns the answer-back byte, and the registers keep their values.
- R11: The answer-back byte carries the can-input flag in bit 7, the can-output flag in bit 6 and the interactive flag in bit 5. Bits 4:0 hold the device type code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Local synchronous reset, active low |
| addr_stb_n | input | 1 | Address-out strobe, active low |
| cmd_stb_n | input | 1 | Command-out strobe, active low |
| dat_stb_n | input | 1 | Data-out strobe, active low |
| stat_gate_n | input | 1 | Status read gate, active low |
| data_gate_n | input | 1 | Data read gate, active low |
| bus_reset_n | input | 1 | Bus-wide reset strobe, active low |
| bus_in_n | input | W | Data line pin levels (low = logical 1) |
| pull_low_o | output | W | Per-line open-drain pull-down request |
| drive_en_o | output | 1 | Device is driving the bus |

## Verification
The bench builds the block with `DEV_ADDR`=0x2A and an answer-back of input yes, output no, interactive yes and type 3, which gives 0xA3. With these values every flag bit has a known, distinct level. It sweeps all 256 address bytes, so exactly one of them preselects, and it also covers address 0. It then sweeps all 256 command values and their complemented data values through the loopback, so every pull-down line is exercised at both levels.

// File: rtl/periph_select_resp.sv
module periph_select_resp #(
  parameter int W = 8,
  parameter logic [W-1:0] DEV_ADDR = 8'h01,
  parameter bit CAN_IN = 1'b1,
  parameter bit CAN_OUT = 1'b1,
  parameter bit INTERACTIVE = 1'b0,
  parameter logic [W-4:0] DEV_TYPE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         addr_stb_n,
  input  logic         cmd_stb_n,
  input  logic         dat_stb_n,
  input  logic         stat_gate_n,
  input  logic         data_gate_n,
  input  logic         bus_reset_n,
  input  logic [W-1:0] bus_in_n,
  output logic [W-1:0] pull_low_o,
  output logic         drive_en_o
);
  localparam logic [W-1:0] ABC = {CAN_IN, CAN_OUT, INTERACTIVE, DEV_TYPE};
  localparam logic [1:0] S_IDLE = 2'd0, S_PRE = 2'd1, S_SEL = 2'd2;
  localparam int NSTB = 5;

  logic [NSTB-1:0] prev_q;
  logic [1:0]      sel_q;
  logic [W-1:0]    cmd_q, dat_q, rd_q;
  logic            own_q;

  wire [NSTB-1:0] stb_now = {~addr_stb_n, ~cmd_stb_n, ~dat_stb_n, ~stat_gate_n, ~data_gate_n};
  wire [NSTB-1:0] hit     = stb_now & ~prev_q;
  wire [W-1:0]    bus_val = ~bus_in_n;
  wire            gate_on = stb_now[1] | stb_now[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      sel_q  <= S_IDLE;
      cmd_q  <= '0;
      dat_q  <= '0;
      rd_q   <= '0;
      own_q  <= 1'b0;
    end else begin
      prev_q <= stb_now;
      if (!bus_reset_n) begin
        sel_q <= S_IDLE;
        cmd_q <= '0;
        dat_q <= '0;
        own_q <= 1'b0;
      end else if (hit[4]) begin
        sel_q <= (bus_val == DEV_ADDR) ? S_PRE : S_IDLE;
        own_q <= 1'b0;
      end else begin
        if (!gate_on) own_q <= 1'b0;
        if (sel_q == S_SEL && hit[3]) cmd_q <= bus_val;
        if (sel_q == S_SEL && hit[2]) dat_q <= bus_val;
        if (hit[0] && sel_q == S_SEL) begin
          rd_q  <= dat_q;
          own_q <= 1'b1;
        end else if (hit[1] && sel_q == S_SEL) begin
          rd_q  <= cmd_q;
          own_q <= 1'b1;
        end else if (hit[1] && sel_q == S_PRE) begin
          rd_q  <= ABC;
          own_q <= 1'b1;
          sel_q <= S_SEL;
        end
      end
    end
  end

  assign drive_en_o = own_q & gate_on & bus_reset_n;
  assign pull_low_o = drive_en_o ? rd_q : '0;
endmodule

// File: rtl/periph_select_resp_chk.sv
module periph_select_resp_chk #(
  parameter int W = 8,
  parameter logic [W-1:0] DEV_ADDR = 8'h01
) (
  input logic         clk,
  input logic         rst_n,
  input logic         addr_stb_n,
  input logic         stat_gate_n,
  input logic         data_gate_n,
  input logic         bus_reset_n,
  input logic [W-1:0] bus_in_n,
  input logic         drive_en_o,
  input logic [1:0]   state_i,
  input logic [W-1:0] cmd_i,
  input logic [W-1:0] dat_i
);
  p_drive_needs_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en_o |-> (!stat_gate_n || !data_gate_n));

  p_bus_reset_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_reset_n |=> (state_i == 2'd0 && cmd_i == '0 && dat_i == '0));

  p_mismatch_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(addr_stb_n) && bus_reset_n && (~bus_in_n != DEV_ADDR)) |=> state_i == 2'd0);

  p_answer_back_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == 2'd1 && $fell(stat_gate_n) && addr_stb_n && bus_reset_n) |=> state_i == 2'd2);

  p_cmd_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i != 2'd2 && bus_reset_n) |=> $stable(cmd_i));

  p_dat_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i != 2'd2 && bus_reset_n) |=> $stable(dat_i));
endmodule

bind periph_select_resp periph_select_resp_chk #(.W(W), .DEV_ADDR(DEV_ADDR)) chk_i (
  .clk(clk), .rst_n(rst_n), .addr_stb_n(addr_stb_n), .stat_gate_n(stat_gate_n),
  .data_gate_n(data_gate_n), .bus_reset_n(bus_reset_n), .bus_in_n(bus_in_n),
  .drive_en_o(drive_en_o), .state_i(sel_q), .cmd_i(cmd_q), .dat_i(dat_q)
);

// File: tb/periph_select_resp_tb_top.sv
module periph_select_resp_tb_top;
  localparam logic [7:0] DEV = 8'h2A;
  localparam logic [7:0] ABC = 8'hA3;
  localparam int AOS = 4, COS = 3, DOS = 2, GSI = 1, GDI = 0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] stb_n = '1;
  logic bus_reset_n = 1'b1;
  logic [7:0] bus_in_n = '1;
  logic [7:0] pull_low_o;
  logic drive_en_o;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  periph_select_resp #(.W(8), .DEV_ADDR(DEV), .CAN_IN(1'b1), .CAN_OUT(1'b0),
    .INTERACTIVE(1'b1), .DEV_TYPE(5'd3)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_stb_n(stb_n[AOS]), .cmd_stb_n(stb_n[COS]),
    .dat_stb_n(stb_n[DOS]), .stat_gate_n(stb_n[GSI]), .data_gate_n(stb_n[GDI]),
    .bus_reset_n(bus_reset_n), .bus_in_n(bus_in_n), .pull_low_o(pull_low_o),
    .drive_en_o(drive_en_o));

  task automatic chk(input bit ok, input string tag, input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [7:0] v);
    @(negedge clk);
    bus_in_n = ~v;
    stb_n[idx] = 1'b0;
    @(negedge clk);
    stb_n[idx] = 1'b1;
    bus_in_n = '1;
    @(negedge clk);
  endtask

  task automatic rd(input int idx, input bit exp_en, input logic [7:0] exp_v, input string tag);
    logic [7:0] ev;
    ev = exp_en ? exp_v : 8'h00;
    @(negedge clk);
    stb_n[idx] = 1'b0;
    @(negedge clk);
    chk(drive_en_o == exp_en && pull_low_o == ev, tag, {drive_en_o, pull_low_o}, {exp_en, ev});
    @(negedge clk);
    chk(drive_en_o == exp_en && pull_low_o == ev, {tag, " hold R7"}, {drive_en_o, pull_low_o}, {exp_en, ev});
    stb_n[idx] = 1'b1;
    #1;
    chk(!drive_en_o && pull_low_o == 8'h00, "R7 release", {drive_en_o, pull_low_o}, 9'h000);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!drive_en_o && pull_low_o == 0, "R1 reset idle", {drive_en_o, pull_low_o}, 9'h000);
    rd(GSI, 1'b0, 8'h00, "R1 deselected gate");
    rd(GDI, 1'b0, 8'h00, "R1 deselected data gate");

    for (int a = 0; a < 256; a++) begin
      wr(AOS, a[7:0]);
      if (a[7:0] == DEV) begin
        rd(GSI, 1'b1, ABC, "R2 answer-back");
        rd(GSI, 1'b1, 8'h00, "R4/R1 status after select");
      end else begin
        rd(GSI, 1'b0, 8'h00, "R3 other address");
      end
    end

    wr(AOS, DEV);
    wr(COS, 8'h55);
    wr(DOS, 8'h66);
    rd(GDI, 1'b0, 8'h00, "R6 data gate while preselected");
    rd(GSI, 1'b1, ABC, "R6 answer-back still pending");
    chk(pull_low_o == 0, "R7 idle", {1'b0, pull_low_o}, 9'h000);
    rd(GSI, 1'b1, 8'h00, "R6 command ignored when preselected");
    rd(GDI, 1'b1, 8'h00, "R6 data ignored when preselected");

    wr(AOS, DEV);
    @(negedge clk);
    stb_n[GSI] = 1'b0;
    @(negedge clk);
    chk(pull_low_o[7] == 1'b1, "R11 input flag", {1'b0, pull_low_o}, {1'b0, ABC});
    chk(pull_low_o[6] == 1'b0, "R11 output flag", {1'b0, pull_low_o}, {1'b0, ABC});
    chk(pull_low_o[5] == 1'b1, "R11 interactive flag", {1'b0, pull_low_o}, {1'b0, ABC});
    chk(pull_low_o[4:0] == 5'd3, "R11 type code", {4'h0, pull_low_o[4:0]}, 9'h003);
    stb_n[GSI] = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 256; v++) begin
      wr(COS, v[7:0]);
      wr(DOS, ~v[7:0]);
      rd(GSI, 1'b1, v[7:0], "R5/R8 command loopback");
      rd(GDI, 1'b1, ~v[7:0], "R5/R8 data loopback");
    end

    wr(AOS, 8'h00);
    wr(COS, 8'h11);
    wr(DOS, 8'h22);
    rd(GSI, 1'b0, 8'h00, "R10 addressed away");
    wr(AOS, DEV);
    rd(GSI, 1'b1, ABC, "R10 reselect answer-back");
    rd(GSI, 1'b1, 8'hFF, "R10 command kept");
    rd(GDI, 1'b1, 8'h00, "R10 data kept");

    @(negedge clk);
    stb_n[GSI] = 1'b0;
    @(negedge clk);
    bus_reset_n = 1'b0;
    #1;
    chk(!drive_en_o, "R9 drive off in bus reset", {8'h00, drive_en_o}, 9'h000);
    @(negedge clk);
    stb_n[GSI] = 1'b1;
    bus_reset_n = 1'b1;
    @(negedge clk);
    rd(GSI, 1'b0, 8'h00, "R9 deselected after bus reset");
    wr(AOS, DEV);
    rd(GSI, 1'b1, ABC, "R9 reselect");
    rd(GSI, 1'b1, 8'h00, "R9 command cleared");
    rd(GDI, 1'b1, 8'h00, "R9 data cleared");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule